// File: doc/BRIEF.md
# BCH8 Sector Error-Location Applier

This block sits after an 8-error BCH locator that serves one 512-byte sector protected by 14 ECC bytes. The 14th ECC byte is reserved and always counts as zero. On `start` the block takes the computed ECC bytes and the ECC bytes stored in the spare area and spends one cycle on two shortcuts. If the 13 meaningful computed bytes are all zero, the sector is clean. If all 14 stored bytes are 0xFF, the page is erased. In either case the block finishes at once and reports zero corrections.

Otherwise it presents the 13 computed bytes in reversed order to the locator and raises a request. It then waits for the locator's answer: either a failure flag, or a count and a list of error bit locations. The block applies the list one entry per clock. Locations are counted backwards from the end of the 525-byte codeword. Each location becomes either a single-bit flip command for the data buffer, a flip command for the stored ECC bytes, or an invalid-location error. At the end the block reports the number of corrections, or an error flag.

Top module: `bch8_loc_apply`

## Requirements
- R1: After reset the block is idle: `done`, `loc_req` and `flip_valid` are low, and `result_err` and `result_cnt` are 0.
- R2: If computed ECC bytes 0..12 (byte k at `calc_ecc[8k+7:8k]`) are all zero, `done` pulses on the second cycle after `start` is sampled. The result is zero corrections with no error. `loc_req` is never raised, and computed byte 13 does not affect this.
- R3: If computed bytes 0..12 are not all zero and all 14 stored bytes are 0xFF, the block finishes exactly as in R2.
- R4: While waiting for the locator, `loc_req` stays high until `loc_valid` is sampled. `loc_syn` byte k carries computed byte 12−k.
- R5: `loc_valid` with `loc_fail` high ends the operation with `result_err`=1 and `result_cnt`=0, and issues no flips.
- R6: For location L, the byte position is 524 − ⌊L/8⌋ and the bit is L mod 8. `flip_mask` is one-hot, with bit (L mod 8) set.
- R7: A position below 512 gives a data flip (`flip_to_ecc`=0, `flip_idx`=position). A position from 512 to 524 gives an ECC flip (`flip_to_ecc`=1, `flip_idx`=position−512).
- R8: When ⌊L/8⌋ > 524, the location is invalid. It issues no flip, the other entries are still applied, and the operation ends with `result_err`=1 and `result_cnt`=0.
- R9: Entry i sits at `loc_list[13i+12:13i]`. Entries are applied in index order, one per cycle. A `loc_count` above 8 is clamped to 8.
- R10: With no invalid entry, `result_cnt` equals the applied count. A count of 0 finishes with zero corrections and no error.
- R11: `start` is ignored while an operation is in progress.
- R12: `done` is a one-cycle pulse. `result_err` and `result_cnt` change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| calc_ecc | input | 112 | Computed ECC bytes; inputs must be held until `done` |
| stored_ecc | input | 112 | ECC bytes read from the spare area |
| loc_req | output | 1 | Request to the locator |
| loc_syn | output | 104 | Computed bytes 0..12, reversed, for the locator |
| loc_valid | input | 1 | Locator answer valid |
| loc_fail | input | 1 | Locator reports an uncorrectable sector |
| loc_count | input | 4 | Number of error locations |
| loc_list | input | 104 | Up to 8 packed 13-bit bit locations |
| flip_valid | output | 1 | Flip command strobe |
| flip_to_ecc | output | 1 | 1: flip targets stored ECC bytes, 0: data bytes |
| flip_idx | output | 10 | Byte index within the target |
| flip_mask | output | 8 | One-hot bit mask |
| done | output | 1 | Operation complete pulse |
| result_err | output | 1 | Locator failure or invalid location |
| result_cnt | output | 4 | Number of corrections applied |

## Verification
On every cycle the assertions check several invariants. Each flip has a one-hot mask and a target index inside its area. No flip or `done` overlaps a pending request. `done` lasts one cycle and the results move only with it. An error result carries a zero count, and a successful count matches the flips actually strobed. Only the directed scenarios can show the things that depend on values. These are the exact position arithmetic at the data/ECC/invalid boundaries, the reversal of the locator bytes, the clamping of the count, list order, the two shortcuts including their timing, and a `start` ignored mid-operation.

// File: rtl/bch8_loc_apply.sv
module bch8_loc_apply #(
  parameter int DATA_BYTES = 512,
  parameter int ECC_BYTES  = 14,
  parameter int MAX_LOC    = 8,
  parameter int LOC_W      = 13,
  parameter int IDX_W      = 10,
  parameter int CNT_W      = $clog2(MAX_LOC + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ECC_BYTES*8-1:0]      calc_ecc,
  input  logic [ECC_BYTES*8-1:0]      stored_ecc,
  output logic                        loc_req,
  output logic [(ECC_BYTES-1)*8-1:0]  loc_syn,
  input  logic                        loc_valid,
  input  logic                        loc_fail,
  input  logic [CNT_W-1:0]            loc_count,
  input  logic [MAX_LOC*LOC_W-1:0]    loc_list,
  output logic                        flip_valid,
  output logic                        flip_to_ecc,
  output logic [IDX_W-1:0]            flip_idx,
  output logic [7:0]                  flip_mask,
  output logic                        done,
  output logic                        result_err,
  output logic [CNT_W-1:0]            result_cnt
);
  localparam int SYN_BYTES = ECC_BYTES - 1;
  localparam int LAST_POS  = DATA_BYTES + SYN_BYTES - 1;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_WAIT, S_APPLY, S_DONE} st_t;
  st_t state;

  logic [MAX_LOC*LOC_W-1:0] list_q;
  logic [CNT_W-1:0]         cnt_q, idx_q;
  logic                     bad_q;

  wire calc_zero = ~|calc_ecc[SYN_BYTES*8-1:0];
  wire erased    = &stored_ecc;

  for (genvar k = 0; k < SYN_BYTES; k++) begin : g_rev
    assign loc_syn[8*k +: 8] = calc_ecc[8*(SYN_BYTES-1-k) +: 8];
  end

  wire [LOC_W-1:0] cur_loc  = list_q[idx_q*LOC_W +: LOC_W];
  wire [15:0]      off      = 16'(cur_loc >> 3);
  wire             in_range = off <= 16'(LAST_POS);
  wire [15:0]      pos      = 16'(LAST_POS) - off;
  wire             last     = idx_q == cnt_q - 1'b1;
  wire             bad_nx   = bad_q | ~in_range;
  wire [CNT_W-1:0] n_clamp  = (loc_count > CNT_W'(MAX_LOC)) ? CNT_W'(MAX_LOC) : loc_count;

  assign loc_req     = state == S_WAIT;
  assign done        = state == S_DONE;
  assign flip_valid  = (state == S_APPLY) && in_range;
  assign flip_to_ecc = pos >= 16'(DATA_BYTES);
  assign flip_idx    = IDX_W'(flip_to_ecc ? pos - 16'(DATA_BYTES) : pos);
  assign flip_mask   = 8'b1 << cur_loc[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      list_q     <= '0;
      cnt_q      <= '0;
      idx_q      <= '0;
      bad_q      <= 1'b0;
      result_err <= 1'b0;
      result_cnt <= '0;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_CHECK;
        S_CHECK: begin
          if (calc_zero || erased) begin
            result_err <= 1'b0;
            result_cnt <= '0;
            state      <= S_DONE;
          end else state <= S_WAIT;
        end
        S_WAIT: if (loc_valid) begin
          if (loc_fail) begin
            result_err <= 1'b1;
            result_cnt <= '0;
            state      <= S_DONE;
          end else begin
            list_q <= loc_list;
            cnt_q  <= n_clamp;
            idx_q  <= '0;
            bad_q  <= 1'b0;
            if (n_clamp == '0) begin
              result_err <= 1'b0;
              result_cnt <= '0;
              state      <= S_DONE;
            end else state <= S_APPLY;
          end
        end
        S_APPLY: begin
          bad_q <= bad_nx;
          if (last) begin
            result_err <= bad_nx;
            result_cnt <= bad_nx ? '0 : cnt_q;
            state      <= S_DONE;
          end else idx_q <= idx_q + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W:0] flips_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flips_seen <= '0;
    else if (state == S_IDLE && start) flips_seen <= '0;
    else if (flip_valid) flips_seen <= flips_seen + 1'b1;
  end

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flip_valid |-> $countones(flip_mask) == 1);
  p_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flip_valid |-> (flip_to_ecc ? flip_idx < IDX_W'(SYN_BYTES) : flip_idx < IDX_W'(DATA_BYTES)));
  p_req_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loc_req |-> !flip_valid && !done);
  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && result_err |-> result_cnt == '0);
  p_cnt_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !result_err |-> (CNT_W+1)'(result_cnt) == flips_seen);
  p_max_flips_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flips_seen <= (CNT_W+1)'(MAX_LOC));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result_cnt) && $stable(result_err));
  p_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK) && calc_zero |=> done);
endmodule

// File: tb/bch8_loc_apply_bench.sv
module bch8_loc_apply_bench;
  logic clk = 0, rst_n = 0, start = 0;
  logic [111:0] calc_ecc = '0, stored_ecc = '0;
  logic loc_valid = 0, loc_fail = 0;
  logic [3:0] loc_count = '0;
  logic [103:0] loc_list = '0, loc_syn;
  logic loc_req, flip_valid, flip_to_ecc, done, result_err;
  logic [9:0] flip_idx;
  logic [7:0] flip_mask;
  logic [3:0] result_cnt;

  bch8_loc_apply u_bch8_loc_apply (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int nf = 0;
  int f_ecc[16], f_idx[16], f_bit[16];
  bit saw_req;

  always @(negedge clk) if (flip_valid && nf < 16) begin
    f_ecc[nf] = flip_to_ecc;
    f_idx[nf] = flip_idx;
    f_bit[nf] = 0;
    for (int b = 0; b < 8; b++) if (flip_mask[b]) f_bit[nf] = b;
    if ($countones(flip_mask) != 1) f_bit[nf] = -1;
    nf++;
  end
  always @(negedge clk) if (loc_req) saw_req = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one operation; returns cycles from start to done.
  task automatic run_op(input logic [111:0] c, input logic [111:0] s, input bit fail,
                        input int cnt, input int locs[8], input bit poke, output int cyc);
    logic [103:0] lst = '0;
    for (int i = 0; i < 8; i++) lst[i*13 +: 13] = 13'(locs[i]);
    @(negedge clk);
    calc_ecc = c; stored_ecc = s; nf = 0; saw_req = 0;
    start = 1;
    @(negedge clk); start = 0; cyc = 1;
    while (!done && !loc_req) begin @(negedge clk); cyc++; end
    if (loc_req) begin
      for (int k = 0; k < 13; k++)
        chk(loc_syn[8*k +: 8] == c[8*(12-k) +: 8], "R4 syn order", loc_syn[8*k +: 8], c[8*(12-k) +: 8]);
      if (poke) begin
        start = 1; @(negedge clk); start = 0; cyc++;
        chk(loc_req == 1 && !done, "R11 start ignored", loc_req, 1);
      end
      @(negedge clk); cyc++;
      chk(loc_req == 1, "R4 req held", loc_req, 1);
      loc_valid = 1; loc_fail = fail; loc_count = 4'(cnt); loc_list = lst;
      @(negedge clk); cyc++;
      loc_valid = 0; loc_fail = 0;
      while (!done) begin @(negedge clk); cyc++; end
    end
  endtask

  task automatic exp_flip(input int L, output bit v, output int e, output int idx, output int b);
    int p;
    p = 524 - L / 8; b = L % 8;
    v = p >= 0;
    e = p >= 512;
    idx = e ? p - 512 : p;
  endtask

  task automatic check_list(input int n, input int locs[8], input string req);
    int k = 0;
    for (int i = 0; i < n; i++) begin
      bit v; int e, idx, b;
      exp_flip(locs[i], v, e, idx, b);
      if (v) begin
        chk(f_ecc[k] == e, {req, " target"}, f_ecc[k], e);
        chk(f_idx[k] == idx, {req, " index"}, f_idx[k], idx);
        chk(f_bit[k] == b, {req, " bit"}, f_bit[k], b);
        k++;
      end
    end
    chk(nf == k, {req, " flip count"}, nf, k);
  endtask

  localparam logic [111:0] C_NZ = 112'h00_0d0c0b0a090807060504030201;
  localparam logic [111:0] S_NZ = 112'h1234_5678_9abc_def0_1122_3344_5566;
  int none[8] = '{0, 0, 0, 0, 0, 0, 0, 0};

  task automatic t_reset;
    chk(!done && !loc_req && !flip_valid, "R1 idle outputs", {done, loc_req, flip_valid}, 0);
    chk(result_err == 0 && result_cnt == 0, "R1 results", result_cnt, 0);
  endtask

  task automatic t_zero_syn;
    int cyc;
    run_op({8'hA5, 104'h0}, S_NZ, 0, 0, none, 0, cyc);
    chk(cyc == 2, "R2 latency", cyc, 2);
    chk(!saw_req && result_cnt == 0 && !result_err, "R2 result", result_cnt, 0);
    chk(nf == 0, "R2 no flips", nf, 0);
  endtask

  task automatic t_erased;
    int cyc;
    run_op(C_NZ, {112{1'b1}}, 0, 0, none, 0, cyc);
    chk(cyc == 2 && !saw_req, "R3 erased shortcut", cyc, 2);
    chk(result_cnt == 0 && !result_err, "R3 result", result_cnt, 0);
  endtask

  task automatic t_fail;
    int cyc; int l[8] = '{200, 300, 0, 0, 0, 0, 0, 0};
    run_op(C_NZ, S_NZ, 1, 2, l, 0, cyc);
    chk(result_err == 1 && result_cnt == 0, "R5 fail result", result_err, 1);
    chk(nf == 0, "R5 no flips", nf, 0);
  endtask

  task automatic t_valid;
    int cyc; int l[8] = '{0, 103, 104, 4199, 0, 0, 0, 0};
    run_op(C_NZ, S_NZ, 0, 4, l, 0, cyc);
    check_list(4, l, "R6 R7 boundaries");
    chk(!result_err && result_cnt == 4, "R10 count", result_cnt, 4);
  endtask

  task automatic t_invalid;
    int cyc; int l[8] = '{2001, 4200, 57, 8191, 0, 0, 0, 0};
    run_op(C_NZ, S_NZ, 0, 4, l, 0, cyc);
    check_list(4, l, "R8 skip invalid");
    chk(result_err == 1 && result_cnt == 0, "R8 error result", result_err, 1);
  endtask

  task automatic t_clamp;
    int cyc; int l[8] = '{4000, 3001, 2002, 1003, 500, 205, 106, 7};
    run_op(C_NZ, S_NZ, 0, 13, l, 1, cyc);
    check_list(8, l, "R9 order clamp");
    chk(!result_err && result_cnt == 8, "R9 clamp count", result_cnt, 8);
  endtask

  task automatic t_empty;
    int cyc;
    run_op(C_NZ, S_NZ, 0, 0, none, 0, cyc);
    chk(!result_err && result_cnt == 0 && nf == 0, "R10 empty list", result_cnt, 0);
    @(negedge clk);
    chk(!done, "R12 done pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(result_cnt == 0 && !result_err, "R12 result held", result_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero_syn();
    t_erased();
    t_fail();
    t_valid();
    t_invalid();
    t_clamp();
    t_empty();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule